// File: doc/BRIEF.md
# Subtract-Multiplex Array Square Root

This block returns the integer square root of an unsigned radicand. It also returns the remainder if that output is enabled. The datapath is an array of rows, and each row settles one root bit, most significant bit first.

A row shifts the running remainder left by two places and brings in the next pair of radicand bits. It then subtracts a trial value, which is the root found so far with the bits `01` appended. The subtraction runs through a chain of one-bit cells. Each cell either subtracts with borrow or passes its minuend through. The final borrow of the chain drives the select of every cell in the row. When the trial goes negative, the row keeps its shifted remainder and records a 0. Nothing is ever added back, and the trial suffix is never anything other than `01`.

The radicand is grouped into bit pairs from the least significant end. A radicand with an odd number of bits therefore has a single-bit top group. A parameter places a register after every row, which gives a pipeline of one row per cycle. Without those registers the block is combinational from input to output.

Both sides use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. In registered mode the whole array advances together, and it advances only when the output stage is empty or is being taken in that cycle. While `out_valid` is high and `out_ready` is low, every stage holds and `in_ready` is low. An upstream source is expected to keep its radicand stable until it is accepted.

Top module: `sqrt_array`

## Requirements
- R1: For every radicand x of `RAD_W` bits, `out_root` equals floor(sqrt(x)). The root is `ROOT_W` = ceil(`RAD_W`/2) bits wide.
- R2: With the remainder kept, `out_rem` equals x − root², and therefore root² + remainder = x. Its width is `ROOT_W`+2 bits, and the value never exceeds 2·root.
- R3: With an 8-bit radicand, 93 yields a root of 9 and a remainder of 12.
- R4: For an odd `RAD_W` the top radicand bit forms a one-bit group, and every radicand still gets the correct root. For example, with `RAD_W`=7 all 128 values give the correct root.
- R5: In registered mode with `out_ready` held high, a radicand accepted on edge k shows `out_valid` high during the cycle after edge k+`ROOT_W`−1, that is, `ROOT_W` cycles of latency. Results leave in the order they were accepted.
- R6: In registered mode, while `out_valid` is high and `out_ready` is low, `out_root`, `out_rem` and `out_valid` hold their values on the next edge.
- R7: In registered mode `in_ready` is high whenever `out_valid` is low or `out_ready` is high. In combinational mode `out_valid` follows `in_valid` and `in_ready` follows `out_ready` within the same cycle.
- R8: With the remainder disabled, `out_rem` reads 0 and the root is unchanged.
- R9: During and right after reset (active-low `rst_n`), `out_valid` is low and `in_ready` is high.
- R10: Edge radicands give exact results. 0 gives root 0 and remainder 0. The all-ones 32-bit value gives 65535 and 131070. Every perfect square gives remainder 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Radicand offered |
| in_ready | output | 1 | Array can take a radicand this cycle |
| in_radicand | input | RAD_W | Unsigned radicand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_root | output | ROOT_W | Integer square root |
| out_rem | output | ROOT_W+2 | Radicand minus root squared, or 0 when disabled |

## Verification
The hardest case to reach is a full pipeline that is held by back-pressure. The held slot must keep its result exactly, and the stages behind it must not move. To reach it, `out_ready` is dropped at random about a third of the time while radicands are offered most cycles, so stalls often fall on a full array. The rows that reject their trial at the widest positions are the other awkward paths. These are driven with all-ones, a perfect square and its predecessor at 32 bits, and exhaustively at 7 and 8 bits.

// File: rtl/sqrt_pkg.sv
package sqrt_pkg;

  // Root width for a radicand of rad_w bits (odd widths gain a zero top bit).
  function automatic int root_width(input int rad_w);
    return (rad_w + 1) / 2;
  endfunction

  // Width of one row's subtract chain: shifted remainder plus incoming pair.
  function automatic int row_width(input int root_w);
    return root_w + 2;
  endfunction

endpackage

// File: rtl/sqrt_csm_cell.sv
// One bit of a row: subtract with borrow, or pass the minuend when sel is set.
module sqrt_csm_cell (
  input  logic x_bit,
  input  logic y_bit,
  input  logic b_in,
  input  logic sel_pass,
  output logic d_bit,
  output logic b_out
);
  assign b_out = (~x_bit & y_bit) | (~(x_bit ^ y_bit) & b_in);
  assign d_bit = sel_pass ? x_bit : (x_bit ^ y_bit ^ b_in);
endmodule

// File: rtl/sqrt_row.sv
// One recurrence step: shift in a radicand pair, try (root<<2)|1, keep or pass.
module sqrt_row #(
  parameter int ROOT_W  = 16,
  parameter bit HAS_REM = 1'b1
) (
  input  logic [1:0]        pair,
  input  logic [ROOT_W-1:0] q_in,
  input  logic [ROOT_W-1:0] r_in,
  output logic [ROOT_W-1:0] q_out,
  output logic [ROOT_W+1:0] r_out
);
  localparam int ROW_W = sqrt_pkg::row_width(ROOT_W);

  logic [ROW_W-1:0] x_w;
  logic [ROW_W-1:0] y_w;
  logic [ROW_W-1:0] d_w;
  logic             neg;

  assign x_w = {r_in, pair};
  assign y_w = {q_in, 2'b01};

  for (genvar j = 0; j < ROW_W; j++) begin : g_cell
    logic bin;
    logic bout;
    if (j == 0) begin : g_lsb
      assign bin = 1'b0;
    end else begin : g_mid
      assign bin = g_cell[j-1].bout;
    end
    sqrt_csm_cell u_cell (
      .x_bit   (x_w[j]),
      .y_bit   (y_w[j]),
      .b_in    (bin),
      .sel_pass(neg),
      .d_bit   (d_w[j]),
      .b_out   (bout)
    );
  end

  assign neg   = g_cell[ROW_W-1].bout;
  assign q_out = {q_in[ROOT_W-2:0], ~neg};

  if (HAS_REM) begin : g_rem
    assign r_out = d_w;
  end else begin : g_norem
    assign r_out = '0;
  end
endmodule

// File: rtl/sqrt_stage_reg.sv
// Pipeline slot between rows: a valid bit and the data word, moved on en.
module sqrt_stage_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         vld_d,
  input  logic [W-1:0] dat_d,
  output logic         vld_q,
  output logic [W-1:0] dat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (en) begin
      vld_q <= vld_d;
      dat_q <= dat_d;
    end
  end
endmodule

// File: rtl/sqrt_array.sv
module sqrt_array
  import sqrt_pkg::*;
#(
  parameter  int RAD_W      = 32,
  parameter  bit REGISTERED = 1'b1,
  parameter  bit KEEP_REM   = 1'b1,
  localparam int ROOT_W     = root_width(RAD_W),
  localparam int REM_W      = row_width(ROOT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RAD_W-1:0]  in_radicand,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ROOT_W-1:0] out_root,
  output logic [REM_W-1:0]  out_rem
);
  localparam int RADE_W = 2 * ROOT_W;
  localparam int DAT_W  = ROOT_W + REM_W + RADE_W;

  // Stage k holds what row k consumes; stage ROOT_W is the result.
  logic              sv   [0:ROOT_W];
  logic [ROOT_W-1:0] sq   [0:ROOT_W];
  logic [REM_W-1:0]  sr   [0:ROOT_W];
  logic [RADE_W-1:0] srad [0:ROOT_W];
  logic [ROOT_W-1:0] rq   [0:ROOT_W-1];
  logic [REM_W-1:0]  rr   [0:ROOT_W-1];
  logic              adv;

  assign sv[0]   = in_valid;
  assign sq[0]   = '0;
  assign sr[0]   = '0;
  assign srad[0] = RADE_W'(in_radicand);

  for (genvar i = 0; i < ROOT_W; i++) begin : g_row
    localparam bit LAST_KEEPS = (i != ROOT_W - 1) || KEEP_REM;

    sqrt_row #(
      .ROOT_W (ROOT_W),
      .HAS_REM(LAST_KEEPS)
    ) u_row (
      .pair (srad[i][RADE_W-1-2*i -: 2]),
      .q_in (sq[i]),
      .r_in (sr[i][ROOT_W-1:0]),
      .q_out(rq[i]),
      .r_out(rr[i])
    );

    if (REGISTERED) begin : g_reg
      logic [DAT_W-1:0] pk_q;
      sqrt_stage_reg #(.W(DAT_W)) u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (adv),
        .vld_d(sv[i]),
        .dat_d({rq[i], rr[i], srad[i]}),
        .vld_q(sv[i+1]),
        .dat_q(pk_q)
      );
      assign {sq[i+1], sr[i+1], srad[i+1]} = pk_q;
    end else begin : g_wire
      assign sv[i+1]   = sv[i];
      assign sq[i+1]   = rq[i];
      assign sr[i+1]   = rr[i];
      assign srad[i+1] = srad[i];
    end
  end

  if (REGISTERED) begin : g_flow_reg
    assign adv      = !sv[ROOT_W] || out_ready;
    assign in_ready = adv;
  end else begin : g_flow_comb
    assign adv      = out_ready;
    assign in_ready = out_ready;
  end

  assign out_valid = sv[ROOT_W];
  assign out_root  = sq[ROOT_W];

  if (KEEP_REM) begin : g_out_rem
    assign out_rem = sr[ROOT_W];
  end else begin : g_out_norem
    assign out_rem = '0;
  end
endmodule

// File: rtl/sqrt_array_chk.sv
module sqrt_array_chk #(
  parameter int RAD_W      = 32,
  parameter bit REGISTERED = 1'b1,
  parameter bit KEEP_REM   = 1'b1
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 in_valid,
  input logic                                 in_ready,
  input logic                                 out_valid,
  input logic                                 out_ready,
  input logic [sqrt_pkg::root_width(RAD_W)-1:0] out_root,
  input logic [sqrt_pkg::root_width(RAD_W)+1:0] out_rem
);
  localparam int ROOT_W = sqrt_pkg::root_width(RAD_W);
  localparam int REM_W  = ROOT_W + 2;

  if (KEEP_REM) begin : g_rem_chk
    // R2: remainder never exceeds twice the root
    a_r2_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_rem <= REM_W'({out_root, 1'b0})));
  end

  if (REGISTERED) begin : g_reg_chk
    int unsigned inflight;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inflight <= 0;
      else inflight <= inflight + ((in_valid && in_ready) ? 1 : 0)
                                - ((out_valid && out_ready) ? 1 : 0);
    end

    // R6: a stalled result holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_root) && $stable(out_rem)));

    // R7: an empty output slot always takes input
    a_r7_ready_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

    // R5: no more items in flight than rows
    a_r5_inflight_cap: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= ROOT_W);

    // R5: a result appears only for something accepted earlier
    a_r5_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
      (inflight == 0) |-> !out_valid);
  end
endmodule

bind sqrt_array sqrt_array_chk #(
  .RAD_W     (RAD_W),
  .REGISTERED(REGISTERED),
  .KEEP_REM  (KEEP_REM)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_root (out_root),
  .out_rem  (out_rem)
);

// File: tb/sqrt_array_tb.sv
module sqrt_array_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // 32-bit registered, remainder kept
  logic        d_in_valid = 1'b0, d_out_ready = 1'b0;
  logic [31:0] d_rad = '0;
  logic        d_in_ready, d_out_valid;
  logic [15:0] d_root;
  logic [17:0] d_rem;
  // 7-bit registered, remainder dropped
  logic        o_in_valid = 1'b0, o_out_ready = 1'b0;
  logic [6:0]  o_rad = '0;
  logic        o_in_ready, o_out_valid;
  logic [3:0]  o_root;
  logic [5:0]  o_rem;
  // 8-bit combinational
  logic        c_in_valid = 1'b0, c_out_ready = 1'b0;
  logic [7:0]  c_rad = '0;
  logic        c_in_ready, c_out_valid;
  logic [3:0]  c_root;
  logic [5:0]  c_rem;

  sqrt_array #(.RAD_W(32), .REGISTERED(1'b1), .KEEP_REM(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(d_in_valid), .in_ready(d_in_ready),
    .in_radicand(d_rad), .out_valid(d_out_valid), .out_ready(d_out_ready),
    .out_root(d_root), .out_rem(d_rem));

  sqrt_array #(.RAD_W(7), .REGISTERED(1'b1), .KEEP_REM(1'b0)) u_dut_odd (
    .clk(clk), .rst_n(rst_n), .in_valid(o_in_valid), .in_ready(o_in_ready),
    .in_radicand(o_rad), .out_valid(o_out_valid), .out_ready(o_out_ready),
    .out_root(o_root), .out_rem(o_rem));

  sqrt_array #(.RAD_W(8), .REGISTERED(1'b0), .KEEP_REM(1'b1)) u_dut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(c_in_valid), .in_ready(c_in_ready),
    .in_radicand(c_rad), .out_valid(c_out_valid), .out_ready(c_out_ready),
    .out_root(c_root), .out_rem(c_rem));

  function automatic longint unsigned isqrt(input longint unsigned x);
    longint unsigned lo = 0;
    longint unsigned hi = 65536;
    while (hi - lo > 1) begin
      longint unsigned mid = (lo + hi) / 2;
      if (mid * mid <= x) lo = mid;
      else hi = mid;
    end
    return lo;
  endfunction

  function automatic logic [31:0] pick(input int idx);
    logic [31:0] r;
    case (idx)
      0: return 32'd0;
      1: return 32'd1;
      2: return 32'd2;
      3: return 32'd3;
      4: return 32'hFFFF_FFFF;
      5: return 32'hFFFE_0001;
      6: return 32'hFFFE_0000;
      7: return 32'h8000_0000;
      default: begin
        if (idx % 5 == 0) begin
          r = $urandom % 65536;
          return r * r;
        end
        return $urandom;
      end
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed_set;
    seed_set = $urandom(32'd7741);

    // R9: reset state
    repeat (3) @(negedge clk);
    chk(!d_out_valid, "R9 out_valid in reset", d_out_valid, 0);
    chk(d_in_ready, "R9 in_ready in reset", d_in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!d_out_valid && !o_out_valid, "R9 out_valid after reset", d_out_valid, 0);
    chk(d_in_ready, "R9 in_ready after reset", d_in_ready, 1);

    // R5: latency of a single item
    begin
      int lat;
      d_out_ready = 1'b1;
      d_in_valid  = 1'b1;
      d_rad       = 32'd1000000;
      #1;
      chk(d_in_ready, "R7 ready while empty", d_in_ready, 1);
      @(negedge clk);
      d_in_valid = 1'b0;
      lat = 1;
      while (!d_out_valid && lat < 40) begin
        @(negedge clk);
        lat++;
      end
      chk(lat == 16, "R5 latency", lat, 16);
      chk(d_root == 16'd1000, "R1 root of 1000000", d_root, 1000);
      chk(d_rem == 18'd0, "R10 perfect square rem", d_rem, 0);
      @(negedge clk);
    end

    // R1 R2 R5 R6 R10: streamed 32-bit traffic under random back-pressure
    begin
      longint unsigned pend[$];
      int sent = 0;
      bit last_acc = 1'b1;
      bit prev_stall = 1'b0;
      logic [15:0] prev_root = '0;
      logic [17:0] prev_rem = '0;
      while (sent < 3000 || pend.size() > 0) begin
        @(negedge clk);
        if (prev_stall)
          chk(d_out_valid && d_root == prev_root && d_rem == prev_rem,
              "R6 held result", d_root, prev_root);
        d_out_ready = ($urandom % 10) < 7;
        if (!(d_in_valid && !last_acc)) begin
          if (sent < 3000 && ($urandom % 10) < 8) begin
            d_in_valid = 1'b1;
            d_rad = pick(sent);
          end else begin
            d_in_valid = 1'b0;
          end
        end
        #1;
        if (d_out_valid && d_out_ready) begin
          longint unsigned x, e;
          bit edge_case;
          x = pend.pop_front();
          e = isqrt(x);
          edge_case = (x == 0) || (x == 64'hFFFF_FFFF) || (e * e == x);
          if (edge_case) begin
            chk(d_root == e[15:0], "R10 edge root", d_root, e);
            chk(d_rem == x - e * e, "R10 edge rem", d_rem, x - e * e);
          end else begin
            chk(d_root == e[15:0], "R1 R5 root in order", d_root, e);
            chk(d_rem == x - e * e, "R2 rem", d_rem, x - e * e);
          end
        end
        prev_stall = d_out_valid && !d_out_ready;
        if (prev_stall) begin
          prev_root = d_root;
          prev_rem  = d_rem;
          chk(!d_in_ready, "R6 in_ready low under stall", d_in_ready, 0);
        end
        if (d_in_valid && d_in_ready) begin
          pend.push_back(longint'(d_rad));
          sent++;
          last_acc = 1'b1;
        end else begin
          last_acc = 1'b0;
        end
      end
      @(negedge clk);
      d_in_valid = 1'b0;
    end

    // R4 R8: odd width, every value, remainder disabled
    begin
      int unsigned opend[$];
      int v = 0;
      o_out_ready = 1'b1;
      while (v < 128 || opend.size() > 0) begin
        @(negedge clk);
        if (v < 128) begin
          o_in_valid = 1'b1;
          o_rad = 7'(v);
        end else begin
          o_in_valid = 1'b0;
        end
        #1;
        if (o_out_valid) begin
          int unsigned x;
          longint unsigned e;
          x = opend.pop_front();
          e = isqrt(longint'(x));
          chk(o_root == e[3:0], "R4 odd-width root", o_root, e);
          chk(o_rem == 6'd0, "R8 disabled remainder", o_rem, 0);
        end
        if (o_in_valid && o_in_ready) begin
          opend.push_back(v);
          v++;
        end
      end
      @(negedge clk);
      o_in_valid = 1'b0;
    end

    // R1 R2 R3 R7: combinational variant, every 8-bit value
    for (int v = 0; v < 256; v++) begin
      longint unsigned e;
      @(negedge clk);
      c_rad = 8'(v);
      c_in_valid = v[0];
      c_out_ready = $urandom % 2;
      #1;
      e = isqrt(longint'(v));
      if (v == 93) begin
        chk(c_root == 4'd9, "R3 root of 93", c_root, 9);
        chk(c_rem == 6'd12, "R3 rem of 93", c_rem, 12);
      end else begin
        chk(c_root == e[3:0], "R1 comb root", c_root, e);
        chk(c_rem == 6'(v - e * e), "R2 comb rem", c_rem, v - e * e);
      end
      chk(c_out_valid == c_in_valid, "R7 comb valid", c_out_valid, c_in_valid);
      chk(c_in_ready == c_out_ready, "R7 comb ready", c_in_ready, c_out_ready);
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule